// File: doc/BRIEF.md
# Immediate-Offset Word Load Sequencer

This block carries out one already-decoded word load whose address is a base register plus or minus an immediate. A start strobe delivers the destination register index, the base register index, a zero-extended immediate and four flags. The flags select index-before-access, add or subtract, base writeback, and whether the instruction's condition passed. The unit then reads the base register through one register-file read port and works out the offset address and the access address. It issues a single word read on a valid/ready request channel with a separate response channel.

Once the word arrives, the unit makes all of its register updates in one writeback cycle. It can write the updated base register, the destination register, or both, over two write ports. A load whose destination is the program counter index becomes a branch to the loaded word. If the access address of such a load is not word aligned, the unit raises an error flag and does not branch. An instruction whose condition failed is dropped at once: no read is issued and no register is written. Only a one-cycle completion pulse is produced.

Top module: `imm_load_unit`

## Requirements
- R1: The offset address is base + immediate when the add flag is 1 and base - immediate when it is 0, both modulo 2^32 with no overflow indication.
- R2: The access address is the offset address when the index flag is 1 and the unmodified base value when it is 0. The base register is read on rf_raddr, which carries the base index in the cycle after start.
- R3: Each executed load issues exactly one read request. mem_req_valid rises in the second cycle after start and stays high with a stable mem_req_addr until the cycle in which mem_req_ready is sampled high. After that it stays low until the next start.
- R4: When the writeback flag is 1, wb_base_en pulses in the writeback cycle with wb_base_idx equal to the base index and wb_base_data equal to the offset address, not the access address.
- R5: When the destination index is not 15, wb_dst_en pulses in the writeback cycle with wb_dst_idx equal to the destination index and wb_dst_data equal to the loaded word.
- R6: When the destination index is 15 and access address bits [1:0] are 00, br_valid pulses with br_target equal to the loaded word, and wb_dst_en stays low.
- R7: When the destination index is 15 and access address bits [1:0] are not 00, align_err pulses in the writeback cycle, and both br_valid and wb_dst_en stay low.
- R8: A start with cond_pass 0 issues no read and makes no register write or branch. done is high for exactly the one cycle after the start, and busy stays low.
- R9: For an executed load, done is high for exactly one cycle: the cycle after the response is accepted, which is also the writeback cycle.
- R10: When writeback is on and the base index equals the destination index, only the base write happens (offset address to the base index), and wb_dst_en stays low.
- R11: A start strobe while busy is high is ignored and does not change the result of the load in progress.
- R12: After reset, busy, done, mem_req_valid, wb_base_en, wb_dst_en, br_valid and align_err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Strobe that accepts a decoded load while idle |
| dst_idx | input | 4 | Destination register index (15 is the program counter) |
| base_idx | input | 4 | Base register index |
| imm | input | 32 | Zero-extended byte offset |
| f_index | input | 1 | 1: access at offset address; 0: access at base (post-indexed) |
| f_add | input | 1 | 1: add offset; 0: subtract offset |
| f_wback | input | 1 | 1: write offset address back to the base register |
| cond_pass | input | 1 | 1: condition passed, execute; 0: discard |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data, same cycle as rf_raddr |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | 32 | Read request byte address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| wb_base_en | output | 1 | Base register write enable |
| wb_base_idx | output | 4 | Base register write index |
| wb_base_data | output | 32 | Base register write data |
| wb_dst_en | output | 1 | Destination register write enable |
| wb_dst_idx | output | 4 | Destination register write index |
| wb_dst_data | output | 32 | Destination register write data |
| br_valid | output | 1 | Branch request |
| br_target | output | 32 | Branch target |
| align_err | output | 1 | Misaligned load into the program counter |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A load is in progress |

## Verification
Counted from the clock edge that samples start, the base index is on rf_raddr one cycle later. The request appears one cycle after that and holds until the edge at which ready is seen high. The writeback outputs and done appear one cycle after the edge that accepts the response, and they are gone one cycle later. A condition-failed start gives only done, in the very next cycle. Every scenario task drives inputs and samples outputs on the falling edge, and steps through these cycles one at a time. Each check is placed in the exact cycle where a result is due, and the task also checks that the result is absent in the cycles before and after it.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_READ_BASE = 3'd1,
    ST_MEM_REQ   = 3'd2,
    ST_MEM_WAIT  = 3'd3,
    ST_WRITEBACK = 3'd4
  } ldu_state_e;
endpackage

// File: rtl/ldu_addr_gen.sv
module ldu_addr_gen #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] imm,
  input  logic            add,
  input  logic            index,
  output logic [XLEN-1:0] offset_addr,
  output logic [XLEN-1:0] access_addr
);
  // Offset arithmetic wraps modulo 2^XLEN.
  function automatic logic [XLEN-1:0] offset_of(input logic [XLEN-1:0] b,
                                                input logic [XLEN-1:0] i,
                                                input logic a);
    return a ? (b + i) : (b - i);
  endfunction

  function automatic logic [XLEN-1:0] access_of(input logic [XLEN-1:0] b,
                                                input logic [XLEN-1:0] o,
                                                input logic x);
    return x ? o : b;
  endfunction

  always_comb begin
    offset_addr = offset_of(base, imm, add);
    access_addr = access_of(base, offset_addr, index);
  end
endmodule

// File: rtl/ldu_ctrl.sv
module ldu_ctrl
  import ldu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cond_pass,
  input  logic       mem_req_ready,
  input  logic       mem_rsp_valid,
  output ldu_state_e state,
  output logic       accept,
  output logic       load_base,
  output logic       req_fire,
  output logic       rsp_fire,
  output logic       in_wb,
  output logic       done,
  output logic       busy
);
  ldu_state_e state_d;
  logic       discard_ev;
  logic       discard_q;

  always_comb begin
    accept     = (state == ST_IDLE) && start && cond_pass;
    discard_ev = (state == ST_IDLE) && start && !cond_pass;
    load_base  = (state == ST_READ_BASE);
    req_fire   = (state == ST_MEM_REQ) && mem_req_ready;
    rsp_fire   = (state == ST_MEM_WAIT) && mem_rsp_valid;
    in_wb      = (state == ST_WRITEBACK);
    busy       = (state != ST_IDLE);
    done       = in_wb || discard_q;
  end

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:      if (accept) state_d = ST_READ_BASE;
      ST_READ_BASE: state_d = ST_MEM_REQ;
      ST_MEM_REQ:   if (req_fire) state_d = ST_MEM_WAIT;
      ST_MEM_WAIT:  if (rsp_fire) state_d = ST_WRITEBACK;
      ST_WRITEBACK: state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      discard_q <= 1'b0;
    end else begin
      state     <= state_d;
      discard_q <= discard_ev;
    end
  end

  // R3: the request state is entered only from the base-read state.
  assert_req_after_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM_REQ && $past(state) != ST_MEM_REQ) |-> $past(state) == ST_READ_BASE);

  // R9: an accepted response leads to done in the next cycle.
  assert_rsp_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> done);
endmodule

// File: rtl/ldu_wb_route.sv
module ldu_wb_route #(
  parameter int RIDX       = 4,
  parameter int PC_IDX     = 15,
  parameter int ALIGN_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_wb,
  input  logic                  wback,
  input  logic [RIDX-1:0]       dst_idx,
  input  logic [RIDX-1:0]       base_idx,
  input  logic [ALIGN_BITS-1:0] access_lsb,
  output logic                  base_en,
  output logic                  dst_en,
  output logic                  br_valid,
  output logic                  align_err
);
  logic to_pc;
  logic aligned;
  logic same_reg;

  always_comb begin
    to_pc     = (dst_idx == RIDX'(PC_IDX));
    aligned   = (access_lsb == '0);
    same_reg  = wback && (dst_idx == base_idx);
    base_en   = in_wb && wback;
    // base port wins when both writes target one index
    dst_en    = in_wb && !to_pc && !same_reg;
    br_valid  = in_wb && to_pc && aligned;
    align_err = in_wb && to_pc && !aligned;
  end

  // R6: the program counter index never reaches the destination port.
  assert_no_pc_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_en |-> dst_idx != RIDX'(PC_IDX));

  // R10: the two write ports never carry the same index together.
  assert_port_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (base_en && dst_en) |-> base_idx != dst_idx);
endmodule

// File: rtl/imm_load_unit.sv
module imm_load_unit
  import ldu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX   = 4,
  parameter int PC_IDX = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [RIDX-1:0] dst_idx,
  input  logic [RIDX-1:0] base_idx,
  input  logic [XLEN-1:0] imm,
  input  logic            f_index,
  input  logic            f_add,
  input  logic            f_wback,
  input  logic            cond_pass,
  output logic [RIDX-1:0] rf_raddr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            mem_req_valid,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            wb_base_en,
  output logic [RIDX-1:0] wb_base_idx,
  output logic [XLEN-1:0] wb_base_data,
  output logic            wb_dst_en,
  output logic [RIDX-1:0] wb_dst_idx,
  output logic [XLEN-1:0] wb_dst_data,
  output logic            br_valid,
  output logic [XLEN-1:0] br_target,
  output logic            align_err,
  output logic            done,
  output logic            busy
);
  localparam int WORD_BYTES = XLEN / 8;
  localparam int ALIGN_BITS = $clog2(WORD_BYTES);

  ldu_state_e      state;
  logic            accept, load_base, req_fire, rsp_fire, in_wb;
  logic [RIDX-1:0] dst_q, base_q;
  logic [XLEN-1:0] imm_q;
  logic            index_q, add_q, wback_q;
  logic [XLEN-1:0] offset_c, access_c;
  logic [XLEN-1:0] offset_q, access_q, data_q;

  ldu_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cond_pass(cond_pass),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .state(state), .accept(accept), .load_base(load_base),
    .req_fire(req_fire), .rsp_fire(rsp_fire), .in_wb(in_wb),
    .done(done), .busy(busy)
  );

  ldu_addr_gen #(.XLEN(XLEN)) i_addr (
    .base(rf_rdata), .imm(imm_q), .add(add_q), .index(index_q),
    .offset_addr(offset_c), .access_addr(access_c)
  );

  ldu_wb_route #(.RIDX(RIDX), .PC_IDX(PC_IDX), .ALIGN_BITS(ALIGN_BITS)) i_route (
    .clk(clk), .rst_n(rst_n), .in_wb(in_wb), .wback(wback_q),
    .dst_idx(dst_q), .base_idx(base_q), .access_lsb(access_q[ALIGN_BITS-1:0]),
    .base_en(wb_base_en), .dst_en(wb_dst_en),
    .br_valid(br_valid), .align_err(align_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q    <= '0;
      base_q   <= '0;
      imm_q    <= '0;
      index_q  <= 1'b0;
      add_q    <= 1'b0;
      wback_q  <= 1'b0;
      offset_q <= '0;
      access_q <= '0;
      data_q   <= '0;
    end else begin
      if (accept) begin
        dst_q   <= dst_idx;
        base_q  <= base_idx;
        imm_q   <= imm;
        index_q <= f_index;
        add_q   <= f_add;
        wback_q <= f_wback;
      end
      if (load_base) begin
        offset_q <= offset_c;
        access_q <= access_c;
      end
      if (rsp_fire) data_q <= mem_rsp_data;
    end
  end

  always_comb begin
    rf_raddr      = base_q;
    mem_req_valid = (state == ST_MEM_REQ);
    mem_req_addr  = access_q;
    wb_base_idx   = base_q;
    wb_base_data  = offset_q;
    wb_dst_idx    = dst_q;
    wb_dst_data   = data_q;
    br_target     = data_q;
  end

  // R3: a pending request holds its address until accepted.
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3: an accepted request is not repeated.
  assert_req_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R8: a discarded start leaves no request and no write behind.
  assert_discard_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !cond_pass) |=> (!mem_req_valid && !wb_base_en && !wb_dst_en && !br_valid && !busy));

  // R9: the completion pulse of a load lasts one cycle.
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |=> !done);

  // R7: a branch and an alignment error never coincide.
  assert_branch_or_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_valid && align_err));
endmodule

// File: tb/test_imm_load_unit.sv
`timescale 1ns/1ps
module test_imm_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  dst_idx = '0, base_idx = '0;
  logic [31:0] imm = '0;
  logic        f_index = 1'b0, f_add = 1'b0, f_wback = 1'b0, cond_pass = 1'b0;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata = '0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        wb_base_en, wb_dst_en, br_valid, align_err, done, busy;
  logic [3:0]  wb_base_idx, wb_dst_idx;
  logic [31:0] wb_base_data, wb_dst_data, br_target;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  imm_load_unit i_imm_load_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_idx(dst_idx), .base_idx(base_idx),
    .imm(imm), .f_index(f_index), .f_add(f_add), .f_wback(f_wback), .cond_pass(cond_pass),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wb_base_en(wb_base_en), .wb_base_idx(wb_base_idx), .wb_base_data(wb_base_data),
    .wb_dst_en(wb_dst_en), .wb_dst_idx(wb_dst_idx), .wb_dst_data(wb_dst_data),
    .br_valid(br_valid), .br_target(br_target), .align_err(align_err),
    .done(done), .busy(busy)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      summary();
      $finish;
    end
  end

  // One executed load. req_tag names the requirement for the writeback checks.
  task automatic run_load(input string req_tag, input logic [3:0] t, input logic [3:0] n,
                          input logic [31:0] off, input logic ix, input logic ad, input logic wb,
                          input logic [31:0] base_val, input logic [31:0] word,
                          input int rdy_wait, input logic poke);
    logic [31:0] exp_off, exp_acc;
    logic pc_dst, al, same;
    exp_off = base_val + (ad ? off : (~off + 32'd1));
    exp_acc = ix ? exp_off : base_val;
    pc_dst  = (t == 4'd15);
    al      = (exp_acc[1:0] == 2'b00);
    same    = wb && (t == n);

    @(negedge clk);
    dst_idx = t; base_idx = n; imm = off; f_index = ix; f_add = ad; f_wback = wb;
    cond_pass = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dst_idx = ~t; base_idx = ~n; imm = ~off; f_add = ~ad;
    check("R2", "rf_raddr", {28'd0, rf_raddr}, {28'd0, n});
    check("R3", "no early request", {31'd0, mem_req_valid}, 32'd0);
    rf_rdata = base_val;
    @(negedge clk);
    rf_rdata = 32'hDEAD_BEEF;
    check("R3", "request valid", {31'd0, mem_req_valid}, 32'd1);
    check("R1", "request address", mem_req_addr, exp_acc);
    if (poke) begin
      start = 1'b1; cond_pass = 1'b1; dst_idx = 4'd2; base_idx = 4'd9;
      imm = 32'h0000_0400; f_index = 1'b1; f_add = 1'b1; f_wback = 1'b1;
    end
    for (int i = 0; i < rdy_wait; i++) begin
      @(negedge clk);
      start = 1'b0;
      check("R3", "request held", {31'd0, mem_req_valid}, 32'd1);
      check("R3", "address stable", mem_req_addr, exp_acc);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check("R3", "request dropped after accept", {31'd0, mem_req_valid}, 32'd0);
    check("R9", "no done while waiting", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R3", "no second request", {31'd0, mem_req_valid}, 32'd0);
    mem_rsp_valid = 1'b1; mem_rsp_data = word;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 32'h0;
    check("R9", "done in writeback", {31'd0, done}, 32'd1);
    check("R4", "base write enable", {31'd0, wb_base_en}, {31'd0, wb});
    if (wb) begin
      check("R4", "base write index", {28'd0, wb_base_idx}, {28'd0, n});
      check("R4", "base write data", wb_base_data, exp_off);
    end
    check(req_tag, "dst write enable", {31'd0, wb_dst_en}, {31'd0, !pc_dst && !same});
    if (!pc_dst && !same) begin
      check("R5", "dst write index", {28'd0, wb_dst_idx}, {28'd0, t});
      check("R5", "dst write data", wb_dst_data, word);
    end
    check(req_tag, "branch", {31'd0, br_valid}, {31'd0, pc_dst && al});
    if (pc_dst && al) check("R6", "branch target", br_target, word);
    check(req_tag, "align error", {31'd0, align_err}, {31'd0, pc_dst && !al});
    @(negedge clk);
    check("R9", "done pulse ends", {31'd0, done}, 32'd0);
    check("R11", "idle after load", {31'd0, busy}, 32'd0);
    check("R9", "writes end", {30'd0, wb_base_en, wb_dst_en}, 32'd0);
  endtask

  task automatic run_discard();
    @(negedge clk);
    dst_idx = 4'd4; base_idx = 4'd6; imm = 32'h10; f_index = 1'b1; f_add = 1'b1;
    f_wback = 1'b1; cond_pass = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", "done after discard", {31'd0, done}, 32'd1);
    check("R8", "busy stays low", {31'd0, busy}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8", "no activity", {27'd0, mem_req_valid, wb_base_en, wb_dst_en, br_valid, done}, 32'd0);
    end
    cond_pass = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "reset outputs",
          {25'd0, busy, done, mem_req_valid, wb_base_en, wb_dst_en, br_valid, align_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "idle after reset",
          {25'd0, busy, done, mem_req_valid, wb_base_en, wb_dst_en, br_valid, align_err}, 32'd0);

    run_load("R5",  4'd3,  4'd5, 32'h0000_0024, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'hA5A5_0001, 0, 1'b0);
    run_load("R1",  4'd1,  4'd2, 32'h0000_0020, 1'b1, 1'b0, 1'b0, 32'h0000_0010, 32'h1111_2222, 1, 1'b0);
    run_load("R1",  4'd7,  4'd8, 32'h0000_0008, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFC, 32'h3333_4444, 0, 1'b0);
    run_load("R4",  4'd0,  4'd4, 32'h0000_0008, 1'b1, 1'b1, 1'b1, 32'h0000_2000, 32'h5555_6666, 2, 1'b0);
    run_load("R2",  4'd6,  4'd9, 32'h0000_0010, 1'b0, 1'b0, 1'b1, 32'h0000_3000, 32'h7777_8888, 3, 1'b0);
    run_load("R6",  4'd15, 4'd1, 32'h0000_0004, 1'b1, 1'b1, 1'b0, 32'h0000_5000, 32'h0000_9001, 0, 1'b0);
    run_load("R7",  4'd15, 4'd3, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0000_4001, 32'hCAFE_0000, 0, 1'b0);
    run_load("R7",  4'd15, 4'd3, 32'h0000_0002, 1'b0, 1'b1, 1'b1, 32'h0000_6002, 32'hCAFE_0001, 0, 1'b0);
    run_discard();
    run_load("R10", 4'd5,  4'd5, 32'h0000_000C, 1'b1, 1'b1, 1'b1, 32'h0000_7000, 32'hBBBB_CCCC, 0, 1'b0);
    run_load("R11", 4'd10, 4'd11, 32'h0000_0040, 1'b1, 1'b0, 1'b1, 32'h0000_8000, 32'hDDDD_EEEE, 2, 1'b1);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule